// File: doc/BRIEF.md
# Status Register and Write-Protection Arbiter

This block keeps the control state of a small serial nonvolatile memory and judges every write request against it. It owns a write-enable latch, a two-bit region selector that fences off part of the array, a protect-enable bit that arms the external guard pin, and a busy flag driven by a self-timed write timer. A serial front end, which is not part of this block, decodes the command stream. It then pulses one strobe per decoded command and presents the target address or the new status byte. The block answers with one-cycle grant pulses and with the byte a status read returns.

A status write is staged when its data byte arrives and launched only when the select line is released. The guard pin can therefore still cancel it while the transfer is open. The region and protect-enable bits take their new values only when the timed cycle that carries them ends. The write-enable latch drops at the end of every completed internal write. The reset values of the nonvolatile bits come from a parameter that stands in for the stored contents.

Top module: `wprot_status_unit`

## Requirements
- R1: When idle, `status_byte` reads bit7 = protect-enable, bits 6..4 = 0, bits 3..2 = region selector, bit1 = write-enable latch, bit0 = 0.
- R2: While a timed write cycle runs, `status_byte` reads 8'hFF.
- R3: The latch is 0 after reset. `cmd_latch_set` sets it and `cmd_latch_clr` clears it, whatever the level of `wp_level`. When both arrive together, clear wins.
- R4: With the latch at 0, an array write gives no `array_grant` and does not start a cycle.
- R5: Region selector 00 protects no address. 01 protects the top quarter (1800h-1FFFh for 13 address bits), 10 protects the top half (1000h-1FFFh), and 11 protects the whole array. A write to a protected address gives no grant.
- R6: An accepted array write raises `array_grant` for one cycle, in the cycle after the strobe. `busy` stays high for exactly WRITE_CYCLES cycles, and the latch reads 0 afterwards.
- R7: A status write with the latch set and no hardware lock is staged, then started by `sel_end` with a one-cycle `status_grant`. Data bit7 becomes protect-enable and data bits 3..2 become the region. The new bits appear only when `busy` falls, and the latch is then 0.
- R8: The hardware lock is active only when `wp_level` is 0 and protect-enable is 1. While it is active, status writes are refused and protect-enable stays 1. Array writes are still judged by region alone. When protect-enable is 0, a low pin has no effect.
- R9: If the lock becomes active while a staged status write waits for `sel_end`, that write is dropped: no grant, no cycle, bits unchanged.
- R10: The pin going low after a status cycle has started does not stop its commit.
- R11: A status write with the latch at 0 is refused.
- R12: While `busy` is high, latch set and clear, array writes, status writes and `sel_end` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_level | input | 1 | Guard pin level (0 = low) |
| sel_end | input | 1 | Pulse: select line released |
| cmd_latch_set | input | 1 | Pulse: set write-enable latch |
| cmd_latch_clr | input | 1 | Pulse: clear write-enable latch |
| cmd_status_wr | input | 1 | Pulse: status data byte received |
| status_wdata | input | 8 | New status byte |
| cmd_array_wr | input | 1 | Pulse: array write requested |
| array_addr | input | ADDR_W | Target array address |
| array_grant | output | 1 | One-cycle pulse: array write accepted |
| status_grant | output | 1 | One-cycle pulse: status write started |
| busy | output | 1 | Timed write cycle in progress |
| status_byte | output | 8 | Byte returned by a status read |

## Verification
Corruption of the latch, the region bits or the protect-enable bit shows at `status_byte` in the first idle cycle after it happens. It also shows in the next grant decision, one cycle after the strobe. A wrong timer count appears as a busy window of the wrong length, visible on the edge where `busy` should fall. A staged status write that is lost or wrongly kept shows as a missing or extra `status_grant` in the cycle after `sel_end`. It then shows again in the committed byte once the cycle ends.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] region;
  } nv_t;

  localparam logic [7:0] BUSY_BYTE = 8'hFF;

  function automatic logic [7:0] fmt_status(nv_t nv, logic latch);
    return {nv.lock_en, 3'b000, nv.region, latch, 1'b0};
  endfunction

  function automatic nv_t nv_from_byte(logic [7:0] b);
    return nv_t'({b[7], b[3:2]});
  endfunction

endpackage

// File: rtl/wpa_region_chk.sv
module wpa_region_chk #(
  parameter int ADDR_W = 13
) (
  input  logic [1:0]        region,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (region)
      2'b00:   hit = 1'b0;
      2'b01:   hit = &addr[TOP -: 2];
      2'b10:   hit = addr[TOP];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpa_cycle_timer.sv
module wpa_cycle_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/wprot_status_unit.sv
module wprot_status_unit
  import wpa_pkg::*;
#(
  parameter int         ADDR_W       = 13,
  parameter int         WRITE_CYCLES = 40,
  parameter logic [7:0] NV_DEFAULT   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_level,
  input  logic              sel_end,
  input  logic              cmd_latch_set,
  input  logic              cmd_latch_clr,
  input  logic              cmd_status_wr,
  input  logic [7:0]        status_wdata,
  input  logic              cmd_array_wr,
  input  logic [ADDR_W-1:0] array_addr,
  output logic              array_grant,
  output logic              status_grant,
  output logic              busy,
  output logic [7:0]        status_byte
);
  localparam nv_t NV_RESET = nv_from_byte(NV_DEFAULT);

  logic latch_q, latch_d;
  nv_t  nv_q, nv_d;
  logic pend_q, pend_d;
  nv_t  stage_q, stage_d;
  logic stat_cyc_q, stat_cyc_d;
  logic agrant_q, sgrant_q;

  logic region_hit, done, hw_lock, accept_ok;
  logic arr_go, capture, stat_go, start;
  logic unused_wdata;

  assign unused_wdata = ^{status_wdata[6:4], status_wdata[1:0], NV_DEFAULT[6:4], NV_DEFAULT[1:0]};

  wpa_region_chk #(.ADDR_W(ADDR_W)) u_region (
    .region (nv_q.region),
    .addr   (array_addr),
    .hit    (region_hit)
  );

  wpa_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  // Request qualification
  always_comb begin
    hw_lock   = nv_q.lock_en & ~wp_level;
    accept_ok = ~busy & ~pend_q;
    arr_go    = accept_ok & cmd_array_wr & latch_q & ~region_hit;
    capture   = accept_ok & cmd_status_wr & ~cmd_array_wr & latch_q & ~hw_lock;
    stat_go   = pend_q & sel_end & ~hw_lock;
    start     = arr_go | stat_go;
  end

  // Next state
  always_comb begin
    latch_d    = latch_q;
    nv_d       = nv_q;
    pend_d     = pend_q;
    stage_d    = stage_q;
    stat_cyc_d = stat_cyc_q;

    if (done)                            latch_d = 1'b0;
    else if (accept_ok && cmd_latch_clr) latch_d = 1'b0;
    else if (accept_ok && cmd_latch_set) latch_d = 1'b1;

    if (capture) begin
      pend_d  = 1'b1;
      stage_d = nv_from_byte(status_wdata);
    end else if (pend_q && (hw_lock || sel_end)) begin
      pend_d  = 1'b0;
    end

    if (start)                 stat_cyc_d = stat_go;
    if (done && stat_cyc_q)    nv_d       = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= 1'b0;
      nv_q       <= NV_RESET;
      pend_q     <= 1'b0;
      stage_q    <= NV_RESET;
      stat_cyc_q <= 1'b0;
      agrant_q   <= 1'b0;
      sgrant_q   <= 1'b0;
    end else begin
      latch_q    <= latch_d;
      nv_q       <= nv_d;
      pend_q     <= pend_d;
      stage_q    <= stage_d;
      stat_cyc_q <= stat_cyc_d;
      agrant_q   <= arr_go;
      sgrant_q   <= stat_go;
    end
  end

  assign array_grant  = agrant_q;
  assign status_grant = sgrant_q;
  assign status_byte  = busy ? BUSY_BYTE : fmt_status(nv_q, latch_q);
endmodule

// File: rtl/wpa_checker.sv
module wpa_checker
  import wpa_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wp_level,
  input logic       busy,
  input logic       latch,
  input nv_t        nv,
  input logic       array_grant,
  input logic       status_grant,
  input logic [7:0] status_byte
);
  assert_idle_format_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (status_byte[6:4] == 3'b000 && status_byte[0] == 1'b0));

  assert_busy_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status_byte == 8'hFF);

  assert_start_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(latch));

  assert_latch_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !latch);

  assert_grant_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({array_grant, status_grant}));

  assert_commit_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nv) |-> $fell(busy));

  assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nv.lock_en && !wp_level && !busy) |=> $stable(nv));

  assert_no_locked_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_grant |-> !$past(nv.lock_en && !wp_level));
endmodule

bind wprot_status_unit wpa_checker u_wpa_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wp_level     (wp_level),
  .busy         (busy),
  .latch        (latch_q),
  .nv           (nv_q),
  .array_grant  (array_grant),
  .status_grant (status_grant),
  .status_byte  (status_byte)
);

// File: tb/test_wprot_status_unit.sv
module test_wprot_status_unit;
  localparam int AW = 13;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_level = 1'b1;
  logic          sel_end = 1'b0;
  logic          cmd_latch_set = 1'b0;
  logic          cmd_latch_clr = 1'b0;
  logic          cmd_status_wr = 1'b0;
  logic [7:0]    status_wdata = 8'h00;
  logic          cmd_array_wr = 1'b0;
  logic [AW-1:0] array_addr = '0;
  logic          array_grant, status_grant, busy;
  logic [7:0]    status_byte;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  wprot_status_unit #(.ADDR_W(AW), .WRITE_CYCLES(NC), .NV_DEFAULT(8'h00)) i_wprot_status_unit (
    .clk(clk), .rst_n(rst_n), .wp_level(wp_level), .sel_end(sel_end),
    .cmd_latch_set(cmd_latch_set), .cmd_latch_clr(cmd_latch_clr),
    .cmd_status_wr(cmd_status_wr), .status_wdata(status_wdata),
    .cmd_array_wr(cmd_array_wr), .array_addr(array_addr),
    .array_grant(array_grant), .status_grant(status_grant),
    .busy(busy), .status_byte(status_byte)
  );

  // Behavioural reference model
  int m_left = 0, m_wel = 0, m_wpen = 0, m_bp = 0, m_pend = 0;
  int m_pwpen = 0, m_pbp = 0, m_kstat = 0, m_ag = 0, m_sg = 0, m_lock = 0;

  function automatic bit prot(int a, int bp);
    int top = 1 << AW;
    case (bp)
      0: return 1'b0;
      1: return a >= (top * 3) / 4;
      2: return a >= top / 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] m_byte();
    if (m_left > 0) return 8'hFF;
    return {m_wpen[0], 3'b000, m_bp[1:0], m_wel[0], 1'b0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_wel = 0; m_wpen = 0; m_bp = 0; m_pend = 0;
      m_kstat = 0; m_ag = 0; m_sg = 0;
    end else begin
      m_lock = (m_wpen == 1 && wp_level == 1'b0) ? 1 : 0;
      m_ag = 0; m_sg = 0;
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_wel = 0;
          if (m_kstat == 1) begin m_wpen = m_pwpen; m_bp = m_pbp; end
        end
      end else if (m_pend == 1) begin
        if (m_lock == 1) m_pend = 0;
        else if (sel_end) begin m_pend = 0; m_kstat = 1; m_left = NC; m_sg = 1; end
      end else begin
        if (cmd_array_wr) begin
          if (m_wel == 1 && !prot(int'(array_addr), m_bp)) begin
            m_kstat = 0; m_left = NC; m_ag = 1;
          end
        end else if (cmd_status_wr && m_wel == 1 && m_lock == 0) begin
          m_pend = 1; m_pwpen = int'(status_wdata[7]); m_pbp = int'(status_wdata[3:2]);
        end
        if (cmd_latch_clr) m_wel = 0;
        else if (cmd_latch_set) m_wel = 1;
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if (status_byte !== m_byte() || busy !== (m_left > 0) ||
          array_grant !== m_ag[0] || status_grant !== m_sg[0]) begin
        mismatched++;
        $display("FAIL %s model: byte=%h/%h busy=%b/%b ag=%b/%b sg=%b/%b (actual/expected)",
                 (m_left > 0) ? "R2" : "R1", status_byte, m_byte(), busy, (m_left > 0),
                 array_grant, m_ag[0], status_grant, m_sg[0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL R6 watchdog: actual cycles=%0d expected below 100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic latch_set(); cmd_latch_set = 1; tick(); cmd_latch_set = 0; endtask
  task automatic latch_clr(); cmd_latch_clr = 1; tick(); cmd_latch_clr = 0; endtask
  task automatic arr_wr(int a); array_addr = AW'(a); cmd_array_wr = 1; tick(); cmd_array_wr = 0; endtask
  task automatic stat_wr(logic [7:0] d); status_wdata = d; cmd_status_wr = 1; tick(); cmd_status_wr = 0; endtask
  task automatic sel(); sel_end = 1; tick(); sel_end = 0; endtask
  task automatic wait_idle(); while (busy) tick(); endtask
  task automatic set_status(logic [7:0] d); latch_set(); stat_wr(d); sel(); wait_idle(); endtask

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1;
    tick();
    check("R3 reset byte", status_byte, 8'h00);

    arr_wr(16'h0010);
    check("R4 grant with latch clear", {7'b0, array_grant}, 8'h00);
    check("R4 busy with latch clear", {7'b0, busy}, 8'h00);

    latch_set();
    check("R1 latch in byte", status_byte, 8'h02);
    cmd_latch_set = 1; cmd_latch_clr = 1; tick(); cmd_latch_set = 0; cmd_latch_clr = 0;
    check("R3 clear wins", status_byte, 8'h00);

    latch_set();
    arr_wr(16'h0100);
    check("R6 array grant", {7'b0, array_grant}, 8'h01);
    check("R2 busy byte", status_byte, 8'hFF);
    n = 1;
    while (busy) begin tick(); if (busy) n++; end
    check("R6 busy length", 8'(n), 8'(NC));
    check("R6 latch dropped", status_byte, 8'h00);

    latch_set();
    arr_wr(16'h0200);
    latch_set(); stat_wr(8'h8C); sel(); arr_wr(16'h0300);
    wait_idle(); tick();
    check("R12 commands during busy ignored", status_byte, 8'h00);

    latch_set();
    stat_wr(8'h8C);
    check("R7 not committed while staged", status_byte, 8'h02);
    sel();
    check("R7 status grant", {7'b0, status_grant}, 8'h01);
    wait_idle();
    check("R7 committed byte", status_byte, 8'h8C);

    latch_set();
    arr_wr(16'h0000);
    check("R5 region 11 blocks 0000", {7'b0, array_grant}, 8'h00);
    check("R1 byte region 11", status_byte, 8'h8E);
    latch_clr();

    set_status(8'h84);
    check("R5 region 01 set", status_byte, 8'h84);
    latch_set(); arr_wr(16'h1800);
    check("R5 region 01 blocks 1800", {7'b0, array_grant}, 8'h00);
    arr_wr(16'h17FF);
    check("R5 region 01 allows 17FF", {7'b0, array_grant}, 8'h01);
    wait_idle();

    set_status(8'h88);
    latch_set(); arr_wr(16'h1000);
    check("R5 region 10 blocks 1000", {7'b0, array_grant}, 8'h00);
    arr_wr(16'h0FFF);
    check("R5 region 10 allows 0FFF", {7'b0, array_grant}, 8'h01);
    wait_idle();

    set_status(8'h80);
    latch_set(); arr_wr(16'h1FFF);
    check("R5 region 00 allows 1FFF", {7'b0, array_grant}, 8'h01);
    wait_idle();

    wp_level = 0;
    latch_set(); stat_wr(8'h00); sel();
    check("R8 locked status write refused", {7'b0, status_grant}, 8'h00);
    check("R8 enable kept", status_byte, 8'h82);
    arr_wr(16'h0004);
    check("R8 array write still judged by region", {7'b0, array_grant}, 8'h01);
    wait_idle();

    wp_level = 1;
    set_status(8'h00);
    wp_level = 0;
    latch_set(); stat_wr(8'h88); sel();
    check("R8 pin ignored when enable 0", {7'b0, status_grant}, 8'h01);
    wait_idle();
    check("R8 bits written with pin low", status_byte, 8'h88);

    wp_level = 1;
    latch_set(); stat_wr(8'h00);
    wp_level = 0; tick();
    sel();
    check("R9 staged write cancelled", {7'b0, status_grant}, 8'h00);
    check("R9 bits unchanged", status_byte, 8'h8A);
    latch_clr();

    wp_level = 1;
    latch_set(); stat_wr(8'h00); sel();
    wp_level = 0;
    wait_idle();
    check("R10 running cycle commits", status_byte, 8'h00);
    wp_level = 1;

    stat_wr(8'h8C); sel();
    check("R11 refused with latch clear", {7'b0, status_grant}, 8'h00);
    check("R11 byte unchanged", status_byte, 8'h00);

    repeat (2) tick();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule